// File: doc/BRIEF.md
# Dynamic Operand Scheduler with Register Renaming

This block sits between instruction decode and a shared functional unit. It holds a register alias table and a small pool of waiting stations, and both watch one result bus that carries a producer tag and a value. Each decoded instruction is renamed and parked in a free station. For each source operand the station holds either the value itself or the tag of the station that will produce it. The destination register is then pointed at the new station. If no station is free, decode is held off.

A station whose two operands are both present is offered to the functional unit. When several are ready, the lowest-numbered one goes first. The functional unit, and whatever arbitrates its results onto the bus, sit outside the block. A result enters the block as a broadcast of tag and value. Waiting stations latch the value into any operand that holds that tag. The alias table takes the value only into a register whose latest writer carries that tag. The producing station is released in the same cycle. A broadcast that arrives in the same cycle as an insertion is forwarded straight into the new station's operands. A read port shows any register's current mapping.

Top module: `dyn_sched_unit`

## Requirements
- R1: When every station is busy, `iss_stall_o` is high, and an instruction offered on `iss_valid_i` is neither inserted nor renamed: the alias table and the stations stay unchanged.
- R2: At insertion, a source register marked valid supplies its value and the operand is ready. A source register marked pending supplies its producer tag and the operand waits.
- R3: In the cycle after an insertion, the destination's alias entry reads pending (`peek_valid_o`=0), with `peek_tag_o` equal to the allocated station number. A source that names the same register as the destination sees the mapping from before the insertion.
- R4: A waiting operand whose stored tag equals a broadcast tag (`cdb_valid_i`=1) latches `cdb_value_i` and counts as ready from the next cycle.
- R5: `disp_valid_o` is high exactly when some busy station has both operands ready and has not yet been handed out. A station is handed out once, in the cycle where `disp_valid_o` and `disp_ready_i` are both high.
- R6: Among the ready stations, the one with the lowest index is presented on `disp_tag_o`, `disp_op_o`, `disp_a_o` and `disp_b_o`.
- R7: The tag of a station is its index, 0 to NUM_RS-1. The lowest-numbered free station is the one allocated.
- R8: A broadcast updates an alias entry, setting it valid with the broadcast value, only if that entry is pending and its tag equals the broadcast tag. A valid entry ignores every broadcast.
- R9: The station whose tag is broadcast becomes free at the following clock edge and can be allocated from the next cycle.
- R10: When an insertion coincides with a broadcast whose tag is the pending producer of one of its sources, that operand is inserted as ready with the broadcast value.
- R11: After reset, every register is valid with value 0, no station is busy, `iss_stall_o` is 0 and `disp_valid_o` is 0.
- R12: Dispatched operands always equal the values the sources would have under strict program-order execution. After all work drains, every register is valid and holds its program-order value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Decoded instruction offered |
| iss_op_i | input | OP_W | Operation code, passed through to dispatch |
| iss_dst_i | input | log2(NUM_REGS) | Destination register |
| iss_src1_i | input | log2(NUM_REGS) | First source register |
| iss_src2_i | input | log2(NUM_REGS) | Second source register |
| iss_stall_o | output | 1 | No free station; the offered instruction is not taken |
| disp_valid_o | output | 1 | A ready station is presented |
| disp_ready_i | input | 1 | Functional unit accepts the presented station |
| disp_tag_o | output | log2(NUM_RS) | Tag of the presented station |
| disp_op_o | output | OP_W | Operation of the presented station |
| disp_a_o | output | DATA_W | First operand value |
| disp_b_o | output | DATA_W | Second operand value |
| cdb_valid_i | input | 1 | Result broadcast present |
| cdb_tag_i | input | log2(NUM_RS) | Tag of the producing station |
| cdb_value_i | input | DATA_W | Result value |
| peek_reg_i | input | log2(NUM_REGS) | Register to observe |
| peek_valid_o | output | 1 | Observed register holds a value |
| peek_tag_o | output | log2(NUM_RS) | Pending producer of the observed register |
| peek_value_o | output | DATA_W | Value of the observed register |

## Verification
The risky overlap is an insertion and a result broadcast in the same cycle. The new instruction may read a register whose producer is broadcasting right then, and its destination may be that same register. One directed sequence sets this up: a producer is dispatched, and a consumer of its result is issued in the exact cycle the result comes back. The consumer must then be presented one cycle later with the forwarded value. Random traffic produces many more such collisions, including broadcasts that free a station while the pool is full. Each one is judged against a program-order model of the register values and a model of operand readiness.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned SCHED_NUM_REGS = 8;
  localparam int unsigned SCHED_NUM_RS   = 4;
  localparam int unsigned SCHED_DATA_W   = 16;
  localparam int unsigned SCHED_OP_W     = 3;
  // alias table read port roles
  localparam int unsigned RD_SRC1 = 0;
  localparam int unsigned RD_SRC2 = 1;
  localparam int unsigned RD_PEEK = 2;
  localparam int unsigned RD_NUM  = 3;
endpackage

// File: rtl/pick_lowest.sv
module pick_lowest #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/alias_table.sv
module alias_table #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 2,
  parameter int unsigned NUM_RD   = 3,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_RD-1:0][REG_W-1:0]     rd_addr_i,
  output logic [NUM_RD-1:0]                rd_valid_o,
  output logic [NUM_RD-1:0][TAG_W-1:0]     rd_tag_o,
  output logic [NUM_RD-1:0][DATA_W-1:0]    rd_value_o,
  input  logic                             wr_en_i,
  input  logic [REG_W-1:0]                 wr_reg_i,
  input  logic [TAG_W-1:0]                 wr_tag_i,
  input  logic                             cdb_valid_i,
  input  logic [TAG_W-1:0]                 cdb_tag_i,
  input  logic [DATA_W-1:0]                cdb_value_i
);
  logic              valid_q [NUM_REGS];
  logic [TAG_W-1:0]  tag_q   [NUM_REGS];
  logic [DATA_W-1:0] value_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit_wr, hit_cdb;
    assign hit_wr  = wr_en_i && (wr_reg_i == REG_W'(r));
    assign hit_cdb = cdb_valid_i && !valid_q[r] && (tag_q[r] == cdb_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[r] <= 1'b1;
        tag_q[r]   <= '0;
        value_q[r] <= '0;
      end else if (hit_wr) begin
        valid_q[r] <= 1'b0;  // newest writer wins over a same-cycle broadcast
        tag_q[r]   <= wr_tag_i;
      end else if (hit_cdb) begin
        valid_q[r] <= 1'b1;
        value_q[r] <= cdb_value_i;
      end
    end

    AST_VALID_IGNORES_CDB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q[r] && !hit_wr |=> valid_q[r] && $stable(value_q[r])); // R8
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_valid_o[p] = valid_q[rd_addr_i[p]];
    assign rd_tag_o[p]   = tag_q[rd_addr_i[p]];
    assign rd_value_o[p] = value_q[rd_addr_i[p]];
  end

  AST_LATEST_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !valid_q[$past(wr_reg_i)] && tag_q[$past(wr_reg_i)] == $past(wr_tag_i)); // R3
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 2,
  parameter int unsigned OP_W     = 3,
  parameter int unsigned ENTRY_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              s1_rdy_i,
  input  logic [TAG_W-1:0]  s1_tag_i,
  input  logic [DATA_W-1:0] s1_val_i,
  input  logic              s2_rdy_i,
  input  logic [TAG_W-1:0]  s2_tag_i,
  input  logic [DATA_W-1:0] s2_val_i,
  input  logic              dispatch_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic              busy_q, sent_q, r1_q, r2_q;
  logic [TAG_W-1:0]  t1_q, t2_q;
  logic [DATA_W-1:0] v1_q, v2_q;
  logic [OP_W-1:0]   op_q;
  logic              own_bcast, cap1, cap2;

  assign own_bcast = cdb_valid_i && (cdb_tag_i == TAG_W'(ENTRY_ID));
  assign cap1 = cdb_valid_i && !r1_q && (t1_q == cdb_tag_i);
  assign cap2 = cdb_valid_i && !r2_q && (t2_q == cdb_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; sent_q <= 1'b0; r1_q <= 1'b0; r2_q <= 1'b0;
      t1_q <= '0; t2_q <= '0; v1_q <= '0; v2_q <= '0; op_q <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1; sent_q <= 1'b0; op_q <= op_i;
      r1_q <= s1_rdy_i; t1_q <= s1_tag_i; v1_q <= s1_val_i;
      r2_q <= s2_rdy_i; t2_q <= s2_tag_i; v2_q <= s2_val_i;
    end else if (busy_q) begin
      if (own_bcast) begin
        busy_q <= 1'b0;
        sent_q <= 1'b0;
      end else if (dispatch_i) begin
        sent_q <= 1'b1;
      end
      if (cap1) begin r1_q <= 1'b1; v1_q <= cdb_value_i; end
      if (cap2) begin r2_q <= 1'b1; v2_q <= cdb_value_i; end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && r1_q && r2_q && !sent_q;
  assign op_o    = op_q;
  assign a_o     = v1_q;
  assign b_o     = v2_q;

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q); // R1
  AST_SRC1_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !alloc_i && cap1 |=> r1_q && v1_q == $past(cdb_value_i)); // R4
  AST_SRC2_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !alloc_i && cap2 |=> r2_q && v2_q == $past(cdb_value_i)); // R4
  AST_DISPATCH_READY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_i |-> busy_q && r1_q && r2_q && !sent_q); // R5
  AST_FREE_ON_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && own_bcast |=> !busy_q); // R9
endmodule

// File: rtl/dyn_sched_unit.sv
module dyn_sched_unit
  import sched_pkg::*;
#(
  parameter int unsigned NUM_REGS = SCHED_NUM_REGS,
  parameter int unsigned NUM_RS   = SCHED_NUM_RS,
  parameter int unsigned DATA_W   = SCHED_DATA_W,
  parameter int unsigned OP_W     = SCHED_OP_W,
  localparam int unsigned REG_W   = $clog2(NUM_REGS),
  localparam int unsigned TAG_W   = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  input  logic [REG_W-1:0]  iss_src1_i,
  input  logic [REG_W-1:0]  iss_src2_i,
  output logic              iss_stall_o,
  output logic              disp_valid_o,
  input  logic              disp_ready_i,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_a_o,
  output logic [DATA_W-1:0] disp_b_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  input  logic [REG_W-1:0]  peek_reg_i,
  output logic              peek_valid_o,
  output logic [TAG_W-1:0]  peek_tag_o,
  output logic [DATA_W-1:0] peek_value_o
);
  logic [NUM_RS-1:0] busy, ready;
  logic [OP_W-1:0]   ent_op [NUM_RS];
  logic [DATA_W-1:0] ent_a  [NUM_RS];
  logic [DATA_W-1:0] ent_b  [NUM_RS];
  logic              free_found, iss_fire, disp_fire;
  logic [TAG_W-1:0]  alloc_idx;

  pick_lowest #(.N(NUM_RS)) u_free (
    .req_i(~busy), .found_o(free_found), .idx_o(alloc_idx));
  pick_lowest #(.N(NUM_RS)) u_disp (
    .req_i(ready), .found_o(disp_valid_o), .idx_o(disp_tag_o));

  assign iss_stall_o = !free_found;
  assign iss_fire    = iss_valid_i && free_found;
  assign disp_fire   = disp_valid_o && disp_ready_i;

  logic [RD_NUM-1:0][REG_W-1:0]  rd_addr;
  logic [RD_NUM-1:0]             rd_valid;
  logic [RD_NUM-1:0][TAG_W-1:0]  rd_tag;
  logic [RD_NUM-1:0][DATA_W-1:0] rd_value;

  always_comb begin
    rd_addr          = '0;
    rd_addr[RD_SRC1] = iss_src1_i;
    rd_addr[RD_SRC2] = iss_src2_i;
    rd_addr[RD_PEEK] = peek_reg_i;
  end

  alias_table #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .NUM_RD(RD_NUM)) u_rat (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_value_o(rd_value),
    .wr_en_i(iss_fire), .wr_reg_i(iss_dst_i), .wr_tag_i(alloc_idx),
    .cdb_valid_i, .cdb_tag_i, .cdb_value_i);

  assign peek_valid_o = rd_valid[RD_PEEK];
  assign peek_tag_o   = rd_tag[RD_PEEK];
  assign peek_value_o = rd_value[RD_PEEK];

  // operand fetch with same-cycle broadcast forwarding
  logic [1:0]        opnd_rdy;
  logic [TAG_W-1:0]  opnd_tag [2];
  logic [DATA_W-1:0] opnd_val [2];
  for (genvar s = 0; s < 2; s++) begin : g_opnd
    logic fwd;
    assign fwd         = !rd_valid[s] && cdb_valid_i && (rd_tag[s] == cdb_tag_i);
    assign opnd_rdy[s] = rd_valid[s] || fwd;
    assign opnd_tag[s] = rd_tag[s];
    assign opnd_val[s] = rd_valid[s] ? rd_value[s] : cdb_value_i;
  end

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .ENTRY_ID(i)) u_ent (
      .clk_i, .rst_ni,
      .alloc_i(iss_fire && (alloc_idx == TAG_W'(i))),
      .op_i(iss_op_i),
      .s1_rdy_i(opnd_rdy[0]), .s1_tag_i(opnd_tag[0]), .s1_val_i(opnd_val[0]),
      .s2_rdy_i(opnd_rdy[1]), .s2_tag_i(opnd_tag[1]), .s2_val_i(opnd_val[1]),
      .dispatch_i(disp_fire && (disp_tag_o == TAG_W'(i))),
      .cdb_valid_i, .cdb_tag_i, .cdb_value_i,
      .busy_o(busy[i]), .ready_o(ready[i]),
      .op_o(ent_op[i]), .a_o(ent_a[i]), .b_o(ent_b[i]));
  end

  assign disp_op_o = ent_op[disp_tag_o];
  assign disp_a_o  = ent_a[disp_tag_o];
  assign disp_b_o  = ent_b[disp_tag_o];

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i && iss_stall_o && !cdb_valid_i |=> &busy); // R1
  AST_LOWEST_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (ready & ((NUM_RS'(1) << disp_tag_o) - NUM_RS'(1))) == '0); // R6
  AST_ALLOC_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_fire |=> busy[$past(alloc_idx)]); // R7
endmodule

// File: tb/dyn_sched_unit_bench.sv
module dyn_sched_unit_bench;
  localparam int NRS = 4, NREG = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        iss_valid, disp_ready, cdb_valid;
  logic [2:0]  iss_op, iss_dst, iss_src1, iss_src2, peek_reg;
  logic [1:0]  cdb_tag;
  logic [15:0] cdb_value;
  logic        iss_stall_o, disp_valid_o, peek_valid_o;
  logic [1:0]  disp_tag_o, peek_tag_o;
  logic [2:0]  disp_op_o;
  logic [15:0] disp_a_o, disp_b_o, peek_value_o;

  dyn_sched_unit u_dyn_sched_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op), .iss_dst_i(iss_dst),
    .iss_src1_i(iss_src1), .iss_src2_i(iss_src2), .iss_stall_o(iss_stall_o),
    .disp_valid_o(disp_valid_o), .disp_ready_i(disp_ready), .disp_tag_o(disp_tag_o),
    .disp_op_o(disp_op_o), .disp_a_o(disp_a_o), .disp_b_o(disp_b_o),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value),
    .peek_reg_i(peek_reg), .peek_valid_o(peek_valid_o), .peek_tag_o(peek_tag_o),
    .peek_value_o(peek_value_o));

  int checks = 0, errors = 0, n_fwd = 0;
  bit done = 0;

  // reference model
  bit          m_busy[NRS], m_sent[NRS], m_r1[NRS], m_r2[NRS];
  logic [1:0]  m_t1[NRS], m_t2[NRS];
  logic [15:0] m_a[NRS], m_b[NRS];
  logic [2:0]  m_op[NRS];
  bit          m_v[NREG];
  logic [1:0]  m_t[NREG];
  logic [15:0] m_rv[NREG], gold[NREG];
  bit          fu_pend[NRS];
  int          fu_lat[NRS];
  logic [15:0] fu_res[NRS];

  function automatic logic [15:0] alu(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    return a + (b ^ {13'd0, op}) + 16'(op) * 16'd3 + 16'd1;
  endfunction

  function automatic int low_free();
    int r = -1;
    for (int k = NRS - 1; k >= 0; k--) if (!m_busy[k]) r = k;
    return r;
  endfunction

  function automatic int low_ready();
    int r = -1;
    for (int k = NRS - 1; k >= 0; k--) if (m_busy[k] && m_r1[k] && m_r2[k] && !m_sent[k]) r = k;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input logic [2:0] pk);
    int di;
    bit full = 1;
    for (int k = 0; k < NRS; k++) if (!m_busy[k]) full = 0;
    chk(iss_stall_o == full, "R1/R9 stall", iss_stall_o, full);
    di = low_ready();
    chk(disp_valid_o == (di >= 0), "R5 dispatch valid", disp_valid_o, di >= 0);
    if (di >= 0 && disp_valid_o) begin
      chk(disp_tag_o == 2'(di), "R6 lowest ready tag", disp_tag_o, di);
      chk(disp_op_o == m_op[di], "R12 op", disp_op_o, m_op[di]);
      chk(disp_a_o == m_a[di], "R2/R4/R12 operand a", disp_a_o, m_a[di]);
      chk(disp_b_o == m_b[di], "R2/R4/R12 operand b", disp_b_o, m_b[di]);
    end
    chk(peek_valid_o == m_v[pk], "R8 alias valid", peek_valid_o, m_v[pk]);
    if (m_v[pk] && peek_valid_o)
      chk(peek_value_o == m_rv[pk], "R8 alias value", peek_value_o, m_rv[pk]);
    else if (!m_v[pk] && !peek_valid_o)
      chk(peek_tag_o == m_t[pk], "R3/R7 alias tag", peek_tag_o, m_t[pk]);
  endtask

  task automatic step(input logic iv, input logic [2:0] op, input logic [2:0] dst,
                      input logic [2:0] s1, input logic [2:0] s2, input logic fr,
                      input logic cv, input logic [1:0] ct, input logic [15:0] cval,
                      input logic [2:0] pk);
    int fi, di;
    bit ok1, ok2;
    logic [1:0] t1, t2;
    logic [15:0] a, b;
    iss_valid = iv; iss_op = op; iss_dst = dst; iss_src1 = s1; iss_src2 = s2;
    disp_ready = fr; cdb_valid = cv; cdb_tag = ct; cdb_value = cval; peek_reg = pk;
    fi = low_free(); di = low_ready();
    a = gold[s1]; b = gold[s2];
    ok1 = m_v[s1]; t1 = m_t[s1];
    ok2 = m_v[s2]; t2 = m_t[s2];
    if (!ok1 && cv && t1 == ct) begin ok1 = 1; if (iv && fi >= 0) n_fwd++; end
    if (!ok2 && cv && t2 == ct) begin ok2 = 1; if (iv && fi >= 0) n_fwd++; end
    if (cv) begin
      for (int k = 0; k < NRS; k++) if (m_busy[k]) begin
        if (!m_r1[k] && m_t1[k] == ct) m_r1[k] = 1;
        if (!m_r2[k] && m_t2[k] == ct) m_r2[k] = 1;
      end
      m_busy[ct] = 0; m_sent[ct] = 0; fu_pend[ct] = 0;
      for (int r = 0; r < NREG; r++)
        if (!m_v[r] && m_t[r] == ct) begin m_v[r] = 1; m_rv[r] = cval; end
    end
    for (int k = 0; k < NRS; k++) if (fu_pend[k] && fu_lat[k] > 0) fu_lat[k]--;
    if (fr && di >= 0) begin
      m_sent[di] = 1; fu_pend[di] = 1; fu_lat[di] = int'($urandom % 4);
      fu_res[di] = alu(m_op[di], m_a[di], m_b[di]);
    end
    if (iv && fi >= 0) begin
      m_busy[fi] = 1; m_sent[fi] = 0; m_op[fi] = op;
      m_r1[fi] = ok1; m_t1[fi] = t1; m_a[fi] = a;
      m_r2[fi] = ok2; m_t2[fi] = t2; m_b[fi] = b;
      m_v[dst] = 0; m_t[dst] = 2'(fi); gold[dst] = alu(op, a, b);
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs(pk);
  endtask

  task automatic pick_cdb(output logic cv, output logic [1:0] ct, output logic [15:0] cval);
    int st = int'($urandom % NRS);
    cv = 0; ct = 0; cval = 0;
    for (int j = 0; j < NRS; j++) begin
      int k = (st + j) % NRS;
      if (!cv && fu_pend[k] && fu_lat[k] == 0 && ($urandom % 4) != 0) begin
        cv = 1; ct = 2'(k); cval = fu_res[k];
      end
    end
  endtask

  initial begin
    logic cv;
    logic [1:0] ct;
    logic [15:0] cval;
    void'($urandom(32'd4471));
    for (int k = 0; k < NRS; k++) begin
      m_busy[k] = 0; m_sent[k] = 0; m_r1[k] = 0; m_r2[k] = 0; fu_pend[k] = 0; fu_lat[k] = 0;
    end
    for (int r = 0; r < NREG; r++) begin m_v[r] = 1; m_t[r] = 0; m_rv[r] = 0; gold[r] = 0; end
    iss_valid = 0; iss_op = 0; iss_dst = 0; iss_src1 = 0; iss_src2 = 0;
    disp_ready = 0; cdb_valid = 0; cdb_tag = 0; cdb_value = 0; peek_reg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(iss_stall_o == 0, "R11 stall after reset", iss_stall_o, 0);
    chk(disp_valid_o == 0, "R11 dispatch after reset", disp_valid_o, 0);
    chk(peek_valid_o == 1 && peek_value_o == 0, "R11 register after reset", peek_value_o, 0);

    // directed: producer, then consumer issued in its broadcast cycle (R10)
    step(1, 3'd1, 3'd1, 3'd2, 3'd3, 0, 0, 0, 0, 3'd1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 3'd1);
    step(1, 3'd2, 3'd4, 3'd1, 3'd1, 0, 1, 2'd0, fu_res[0], 3'd4);
    chk(disp_valid_o && disp_tag_o == 2'd1, "R10 forwarded insert ready", disp_tag_o, 1);
    chk(disp_a_o == gold[1] && disp_b_o == gold[1], "R10 forwarded value", disp_a_o, gold[1]);
    // fill the pool, then a stalled issue must leave r7 untouched (R1)
    step(1, 3'd3, 3'd5, 3'd4, 3'd0, 0, 0, 0, 0, 3'd5);
    step(1, 3'd4, 3'd6, 3'd5, 3'd4, 0, 0, 0, 0, 3'd6);
    step(1, 3'd5, 3'd2, 3'd6, 3'd1, 0, 0, 0, 0, 3'd2);
    chk(iss_stall_o == 1, "R1 full pool stalls", iss_stall_o, 1);
    step(1, 3'd6, 3'd7, 3'd1, 3'd2, 0, 0, 0, 0, 3'd7);
    chk(peek_valid_o == 1 && peek_value_o == 0, "R1 stalled issue leaves alias", peek_valid_o, 1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      pick_cdb(cv, ct, cval);
      step(($urandom % 4) != 0, 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
           ($urandom % 4) != 0, cv, ct, cval, 3'($urandom));
    end
    // drain
    for (int n = 0; n < 400; n++) begin
      bit any = 0;
      for (int k = 0; k < NRS; k++) if (m_busy[k]) any = 1;
      if (!any) break;
      pick_cdb(cv, ct, cval);
      step(0, 0, 0, 0, 0, 1, cv, ct, cval, 3'($urandom));
    end
    for (int r = 0; r < NREG; r++) begin
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 3'(r));
      chk(peek_valid_o == 1, "R12 drained register valid", peek_valid_o, 1);
      chk(peek_value_o == gold[r], "R12 program-order value", peek_value_o, gold[r]);
    end
    chk(n_fwd > 0, "R10 forwarding exercised", n_fwd, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule